// File: doc/BRIEF.md
# Burst Beat Sequencer and Byte-Lane Decoder

This block sits behind the address phase of a 64-bit system bus. It takes one accepted request, described by a burst flag, a 4-bit size code and the low five address bits, and turns it into a series of data-phase beats. For each beat it presents the beat address, an 8-bit byte-lane enable and a last-beat flag. It holds each beat until a per-beat acknowledge is sampled, and then moves on.

A request with the burst flag clear and a size of 1 to 6 bytes gives one beat. The lanes enabled on that beat are the bytes the transfer covers on the bus. A request with the burst flag set and size code 2 moves a 32-byte cache block as four double-word beats. The requested double word goes first, and the beats wrap inside the block. A request the block cannot serve raises a one-cycle error pulse and starts no beats. A new request may be presented in the same cycle as the final acknowledge, so beats can follow each other without a gap.

Top module: `bbs_burst_seq`

## Requirements
- R1: While `rst_n` is low, and until a start is accepted after reset, `beat_valid_o`, `last_o` and `err_o` are 0 and `lane_en_o` is 0.
- R2: A start accepted at a rising edge makes `beat_valid_o` high from the next cycle.
- R3: With `burst_i`=1 and `size_i`=4'b0010, exactly four beats are issued. The first beat's address bits 4:3 equal the requested address bits 4:3.
- R4: Each following burst beat has address bits 4:3 one greater, modulo 4, than the beat before it. All four double words of the 32-byte block therefore appear once.
- R5: On every burst beat, `beat_addr_o[2:0]` is 0 and `lane_en_o` is 8'hFF.
- R6: With `burst_i`=0 and `size_i` of 1 to 6, exactly one beat is issued, with `beat_addr_o` equal to the request address. `lane_en_o[k]` enables byte lane k, and lane 0 is the most significant byte of the bus (bits 63:56). Bit k is set exactly when off ≤ k < off+size, where off is address bits 2:0.
- R7: While `ack_i` is low, the current beat's valid, address, lanes and last flag stay unchanged.
- R8: `last_o` is high only on the final beat of a request. After the final beat is acknowledged, `beat_valid_o` is 0 in the next cycle unless a new start was accepted in that same cycle.
- R9: A start with an undefined size code, or with a single-beat span that crosses the 8-byte boundary (off+size > 8), makes `err_o` high for one cycle after the start edge, with `beat_valid_o` low. No beats follow.
- R10: A start pulse during a beat that is not being finished with its final acknowledge is ignored. The running beats continue unchanged and `err_o` stays low.
- R11: A start in the same cycle as the final beat's acknowledge is accepted. Its first beat, or its error pulse, appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request strobe, sampled at the rising edge |
| burst_i | input | 1 | Burst flag of the request |
| size_i | input | 4 | Size code of the request |
| addr_i | input | 5 | Low address bits of the request |
| ack_i | input | 1 | Acknowledge of the current beat |
| beat_valid_o | output | 1 | A beat is being presented |
| beat_addr_o | output | 5 | Low address bits of the current beat |
| lane_en_o | output | 8 | Byte-lane enables, bit k for lane k, lane 0 most significant |
| last_o | output | 1 | Current beat is the final one of its request |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two things can happen in the same cycle: the final beat of one request is retired, and the next request is accepted. The bench provokes this by raising the acknowledge and the start strobe together on the last burst beat. It does this once with a valid single-beat request, judged by its address and lanes in the next cycle, and once with an undefined request, judged by an error pulse with no beat. A start raised during a beat that is not final checks that the block does not accept a request while a beat is still running. An exhaustive sweep over flag, size and address compares every beat against arithmetic expectations.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } bbs_state_e;
endpackage

// File: rtl/bbs_req_decode.sv
module bbs_req_decode #(
  parameter int LANES      = 8,
  parameter int SIZE_W     = 4,
  parameter int ADDR_W     = 5,
  parameter int BURST_CODE = 2,
  parameter int MAX_SINGLE = 6
) (
  input  logic              burst_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic              is_burst_o,
  output logic [LANES-1:0]  mask_o
);
  localparam int OFF_W = $clog2(LANES);
  localparam int SUM_W = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 1;

  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] size_ext;
  logic [SUM_W-1:0] end_ext;
  logic             burst_ok;
  logic             single_ok;

  always_comb begin
    off_ext   = SUM_W'(addr_i[OFF_W-1:0]);
    size_ext  = SUM_W'(size_i);
    end_ext   = off_ext + size_ext;
    burst_ok  = burst_i && (size_i == SIZE_W'(BURST_CODE));
    single_ok = !burst_i && (size_i != '0) &&
                (size_i <= SIZE_W'(MAX_SINGLE)) &&
                (end_ext <= SUM_W'(LANES));
    ok_o       = burst_ok || single_ok;
    is_burst_o = burst_ok;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [SUM_W-1:0] KV = SUM_W'(k);
    assign mask_o[k] = is_burst_o || ((KV >= off_ext) && (KV < end_ext));
  end
endmodule

// File: rtl/bbs_addr_gen.sv
module bbs_addr_gen #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 3,
  parameter int BEAT_W = 2
) (
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [BEAT_W-1:0] idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BLK_W = OFF_W + BEAT_W;

  logic [BEAT_W-1:0] dw_sel;

  always_comb begin
    dw_sel = base_addr_i[BLK_W-1:OFF_W] + idx_i;
    addr_o = base_addr_i;
    if (burst_i) begin
      addr_o[BLK_W-1:OFF_W] = dw_sel;
      addr_o[OFF_W-1:0]     = '0;
    end
  end
endmodule

// File: rtl/bbs_beat_ctrl.sv
module bbs_beat_ctrl
  import bbs_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int ADDR_W      = 5,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              req_ok_i,
  input  logic              req_burst_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  req_mask_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic [$clog2(BURST_BEATS)-1:0] idx_o,
  output logic              burst_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [LANES-1:0]  mask_o,
  output logic              last_o,
  output logic              err_o
);
  localparam int BEAT_W = $clog2(BURST_BEATS);
  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(BURST_BEATS - 1);

  bbs_state_e        state_q, state_d;
  logic [BEAT_W-1:0] idx_q, idx_d;
  logic              burst_q, burst_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  mask_q, mask_d;
  logic              err_q, err_d;
  logic              is_last;
  logic              accept;
  logic              load_en;
  logic              step_en;

  always_comb begin
    is_last = (state_q == ST_BEAT) && (!burst_q || (idx_q == BEAT_MAX));
    accept  = start_i && ((state_q == ST_IDLE) || (ack_i && is_last));
    load_en = accept && req_ok_i;
    step_en = (state_q == ST_BEAT) && ack_i && !is_last;

    state_d = state_q;
    idx_d   = idx_q;
    burst_d = burst_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    err_d   = accept && !req_ok_i;

    if ((state_q == ST_BEAT) && ack_i && is_last) begin
      state_d = ST_IDLE;
    end
    if (step_en) begin
      idx_d = idx_q + 1'b1;
    end
    if (load_en) begin
      state_d = ST_BEAT;
      idx_d   = '0;
      burst_d = req_burst_i;
      addr_d  = req_addr_i;
      mask_d  = req_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (load_en || step_en) begin
        idx_q <= idx_d;
      end
      if (load_en) begin
        burst_q <= burst_d;
        addr_q  <= addr_d;
        mask_q  <= mask_d;
      end
    end
  end

  assign busy_o      = (state_q == ST_BEAT);
  assign idx_o       = idx_q;
  assign burst_o     = burst_q;
  assign base_addr_o = addr_q;
  assign mask_o      = mask_q;
  assign last_o      = is_last;
  assign err_o       = err_q;
endmodule

// File: rtl/bbs_burst_seq.sv
module bbs_burst_seq #(
  parameter int LANES       = 8,
  parameter int BURST_BEATS = 4,
  parameter int ADDR_W      = 5,
  parameter int SIZE_W      = 4,
  parameter int BURST_CODE  = 2,
  parameter int MAX_SINGLE  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic              last_o,
  output logic              err_o
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              req_ok;
  logic              req_burst;
  logic [LANES-1:0]  req_mask;
  logic              busy;
  logic [BEAT_W-1:0] beat_idx;
  logic              cur_burst;
  logic [ADDR_W-1:0] base_addr;
  logic [LANES-1:0]  cur_mask;
  logic              cur_last;
  logic [ADDR_W-1:0] gen_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bbs_req_decode #(
    .LANES(LANES), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W),
    .BURST_CODE(BURST_CODE), .MAX_SINGLE(MAX_SINGLE)
  ) dec_i (
    .burst_i(burst_i), .size_i(size_i), .addr_i(addr_i),
    .ok_o(req_ok), .is_burst_o(req_burst), .mask_o(req_mask)
  );

  bbs_beat_ctrl #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .req_ok_i(req_ok), .req_burst_i(req_burst), .req_addr_i(addr_i),
    .req_mask_i(req_mask), .ack_i(ack_i), .busy_o(busy),
    .idx_o(beat_idx), .burst_o(cur_burst), .base_addr_o(base_addr),
    .mask_o(cur_mask), .last_o(cur_last), .err_o(err_o)
  );

  bbs_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W)
  ) agen_i (
    .burst_i(cur_burst), .base_addr_i(base_addr), .idx_i(beat_idx),
    .addr_o(gen_addr)
  );

  assign beat_valid_o = busy;
  assign beat_addr_o  = busy ? gen_addr : '0;
  assign lane_en_o    = busy ? cur_mask : '0;
  assign last_o       = cur_last;
endmodule

// File: rtl/bbs_burst_seq_chk.sv
module bbs_burst_seq_chk #(
  parameter int LANES       = 8,
  parameter int BURST_BEATS = 4,
  parameter int ADDR_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ack_i,
  input logic              beat_valid_o,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic [LANES-1:0]  lane_en_o,
  input logic              last_o,
  input logic              err_o
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int BEAT_W = $clog2(BURST_BEATS);
  localparam int BLK_W  = OFF_W + BEAT_W;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid_o |-> (!last_o && (lane_en_o == '0))); // R1

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !ack_i) |=> (beat_valid_o && $stable(beat_addr_o) &&
                                  $stable(lane_en_o) && $stable(last_o))); // R7

  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && (&lane_en_o)) |-> (beat_addr_o[OFF_W-1:0] == '0)); // R5

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && (&lane_en_o) && ack_i && !last_o) |=>
      (beat_valid_o && (beat_addr_o[BLK_W-1:OFF_W] ==
        BEAT_W'($past(beat_addr_o[BLK_W-1:OFF_W]) + 1'b1)))); // R4

  AST_LAST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && ack_i && last_o && !start_i) |=> !beat_valid_o); // R8

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !beat_valid_o); // R9

  AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> (lane_en_o != '0)); // R6
endmodule

bind bbs_burst_seq bbs_burst_seq_chk #(
  .LANES(LANES), .BURST_BEATS(BURST_BEATS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
  .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
  .lane_en_o(lane_en_o), .last_o(last_o), .err_o(err_o)
);

// File: tb/bbs_burst_seq_tb_top.sv
module bbs_burst_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       burst_i;
  logic [3:0] size_i;
  logic [4:0] addr_i;
  logic       ack_i;
  logic       beat_valid_o;
  logic [4:0] beat_addr_o;
  logic [7:0] lane_en_o;
  logic       last_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bbs_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_i(burst_i),
    .size_i(size_i), .addr_i(addr_i), .ack_i(ack_i),
    .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
    .lane_en_o(lane_en_o), .last_o(last_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_mask(input int off, input int sz);
    logic [7:0] m;
    m = '0;
    for (int k = 0; k < 8; k++) m[k] = (k >= off) && (k < off + sz);
    return m;
  endfunction

  function automatic bit exp_ok(input int b, input int s, input int a);
    if (b != 0) return (s == 2);
    return (s >= 1) && (s <= 6) && ((a % 8) + s <= 8);
  endfunction

  function automatic logic [4:0] burst_addr(input int a, input int n);
    return 5'(((((a / 8) + n) % 4)) * 8);
  endfunction

  task automatic present(input int b, input int s, input int a);
    start_i = 1'b1;
    burst_i = 1'(b);
    size_i  = 4'(s);
    addr_i  = 5'(a);
  endtask

  task automatic run_req(input int b, input int s, input int a, input int w);
    int nb;
    present(b, s, a);
    tick();
    start_i = 1'b0;
    if (!exp_ok(b, s, a)) begin
      chk("R9 err pulse", 32'(err_o), 1);
      chk("R9 no beat", 32'(beat_valid_o), 0);
      tick();
      chk("R9 single cycle", 32'(err_o), 0);
      chk("R9 stays idle", 32'(beat_valid_o), 0);
      return;
    end
    chk("R9 no err", 32'(err_o), 0);
    nb = (b != 0) ? 4 : 1;
    for (int n = 0; n < nb; n++) begin
      chk("R2 beat valid", 32'(beat_valid_o), 1);
      if (b != 0) begin
        if (n == 0) chk("R3 first dword", 32'(beat_addr_o), 32'(burst_addr(a, 0)));
        else        chk("R4 wrap order", 32'(beat_addr_o), 32'(burst_addr(a, n)));
        chk("R5 burst lanes", 32'(lane_en_o), 32'hFF);
      end else begin
        chk("R6 single addr", 32'(beat_addr_o), 32'(a));
        chk("R6 single lanes", 32'(lane_en_o), 32'(exp_mask(a % 8, s)));
      end
      chk("R8 last flag", 32'(last_o), (n == nb - 1) ? 1 : 0);
      for (int j = 0; j < w; j++) begin
        tick();
        chk("R7 hold valid", 32'(beat_valid_o), 1);
        chk("R7 hold addr", 32'(beat_addr_o),
            (b != 0) ? 32'(burst_addr(a, n)) : 32'(a));
      end
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
    end
    chk("R8 idle after last", 32'(beat_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; burst_i = 1'b0;
    size_i = '0; addr_i = '0; ack_i = 1'b0;
    repeat (3) tick();
    chk("R1 reset valid", 32'(beat_valid_o), 0);
    chk("R1 reset last", 32'(last_o), 0);
    chk("R1 reset err", 32'(err_o), 0);
    chk("R1 reset lanes", 32'(lane_en_o), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 idle after release", 32'(beat_valid_o), 0);

    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 32; a++)
          run_req(b, s, a, (a + s) % 3);

    // R10: start pulse during a non-final beat is ignored
    present(1, 2, 8);
    tick();
    present(0, 1, 0);
    tick();
    start_i = 1'b0;
    chk("R10 addr kept", 32'(beat_addr_o), 8);
    chk("R10 lanes kept", 32'(lane_en_o), 32'hFF);
    chk("R10 no err", 32'(err_o), 0);
    present(0, 4, 1);
    ack_i = 1'b1;
    tick();
    start_i = 1'b0;
    ack_i = 1'b0;
    chk("R10 second beat", 32'(beat_addr_o), 16);
    chk("R10 no err on ack", 32'(err_o), 0);
    ack_i = 1'b1; tick();
    chk("R10 third beat", 32'(beat_addr_o), 24);
    tick();
    chk("R10 fourth beat", 32'(beat_addr_o), 0);
    chk("R10 last", 32'(last_o), 1);
    tick();
    ack_i = 1'b0;
    chk("R10 idle", 32'(beat_valid_o), 0);

    // R11: new valid start on the final acknowledge
    present(1, 2, 24);
    tick();
    start_i = 1'b0;
    ack_i = 1'b1;
    repeat (3) tick();
    chk("R11 on final beat", 32'(last_o), 1);
    present(0, 4, 4);
    tick();
    start_i = 1'b0;
    ack_i = 1'b0;
    chk("R11 back-to-back valid", 32'(beat_valid_o), 1);
    chk("R11 back-to-back addr", 32'(beat_addr_o), 4);
    chk("R11 back-to-back lanes", 32'(lane_en_o), 32'hF0);
    chk("R11 back-to-back last", 32'(last_o), 1);
    // R11: undefined start on the final acknowledge
    present(1, 7, 0);
    ack_i = 1'b1;
    tick();
    start_i = 1'b0;
    ack_i = 1'b0;
    chk("R11 error on final ack", 32'(err_o), 1);
    chk("R11 no beat after error", 32'(beat_valid_o), 0);
    tick();
    chk("R11 error cleared", 32'(err_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule